// File: doc/BRIEF.md
# Framed-Bus Control Timeslot Register

This block owns one 8-bit timeslot of a framed serial time-division bus that carries control and status bytes. A processor-side write loads a transmit byte, which is then shifted out most significant bit first inside that timeslot in every frame until it is replaced. Every frame, the byte arriving in the same timeslot is captured into a read register. The block captures it whether or not transmission is enabled.

The serial side runs off the system clock. A one-cycle `bitTick` strobe marks each bit period, and `frameSync`, high together with a tick, marks bit 0 of a frame. The channel enable `chanEn` gates the transmit drive. When it is low, the timeslot is left undriven (`serOe` low). Both a power-up reset and a software reset pulse preset the transmit byte to all ones. A write made while the timeslot is in progress is held back until the next timeslot begins, so a transmitted byte is never a mix of old and new data.

Top module: `ctrlchan_top`

## Requirements
- R1: Counting the tick that carries `frameSync` as frame bit 0, the channel uses frame bits SLOT_INDEX*8 to SLOT_INDEX*8+7. At every other bit position, `serOe` is low.
- R2: In timeslot bit k (k = 0..7), `serOut` carries bit 7-k of the active transmit byte, so the MSB goes first. `serOut` and `serOe` update one clock after the tick and hold until the next tick.
- R3: If `chanEn` is 0 at a timeslot tick, then `serOe` and `serOut` are both 0 for that bit period.
- R4: After `rst_n` is released, and after a one-cycle `softRst` pulse, the transmit byte is 8'hFF.
- R5: `serIn` sampled at timeslot tick k becomes bit 7-k of `rxByte`. `rxByte` takes the whole byte one clock after the tick of timeslot bit 7.
- R6: Reception into `rxByte` happens whatever the value of `chanEn`.
- R7: A write with `regWrEn` high and `regAddr` equal to TX_ADDR (default 8'h05) sets the byte sent from the next timeslot start onward. A write made during a timeslot does not change the bits still to be sent in that timeslot.
- R8: A write to any other address has no effect on the transmitted byte.
- R9: `rxByte` keeps its value between timeslot ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| softRst | input | 1 | Software reset pulse, presets the transmit byte |
| bitTick | input | 1 | One-cycle strobe per serial bit period |
| frameSync | input | 1 | With bitTick, marks frame bit 0 |
| serIn | input | 1 | Serial receive data |
| serOut | output | 1 | Serial transmit data |
| serOe | output | 1 | Drive enable for serOut; low means tri-state |
| chanEn | input | 1 | Transmit enable for the timeslot |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register write address |
| regWrData | input | 8 | Register write data |
| rxByte | output | 8 | Last byte received in the timeslot |

## Verification
Both serial outputs are registered on the tick, so the bench samples `serOut` and `serOe` at the falling edge that follows the tick, and it does this for every one of the 32 bit positions of each frame. The bench compares `rxByte` at that same point after the tick of timeslot bit 7, and at every other tick it expects the value to be unchanged. Writes go in only on cycles without a tick. The bench model promotes the pending byte at the timeslot's first tick, which is also the cycle in which the design makes the change.

// File: rtl/ctrlchan_pkg.sv
package ctrlchan_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(BYTE_W);

  typedef struct packed {
    logic             slotTick;   // bit tick that falls inside the timeslot
    logic             slotFirst;  // tick of timeslot bit 0
    logic             slotLast;   // tick of timeslot bit 7
    logic [IDX_W-1:0] bitIdx;     // bit number inside the timeslot
  } slotStrobe_t;
endpackage

// File: rtl/ctrlchan_ctl.sv
module ctrlchan_ctl
  import ctrlchan_pkg::*;
#(
  parameter int SLOTS_PER_FRAME = 4,
  parameter int SLOT_INDEX      = 1
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bitTick,
  input  logic        frameSync,
  output slotStrobe_t strb
);
  localparam int FRAME_BITS = SLOTS_PER_FRAME * BYTE_W;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int FIRST_POS  = SLOT_INDEX * BYTE_W;
  localparam int LAST_POS   = FIRST_POS + BYTE_W - 1;

  logic [POS_W-1:0] posReg;
  logic [POS_W-1:0] curPos;
  logic [POS_W-1:0] offset;
  logic             inSlot;

  always_comb begin
    if (frameSync)                               curPos = '0;
    else if (posReg == POS_W'(FRAME_BITS - 1))   curPos = '0;
    else                                         curPos = posReg + 1'b1;
    inSlot = (int'(curPos) >= FIRST_POS) && (int'(curPos) <= LAST_POS);
    offset = curPos - POS_W'(FIRST_POS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       posReg <= POS_W'(FRAME_BITS - 1);
    else if (bitTick) posReg <= curPos;
  end

  always_comb begin
    strb.slotTick  = bitTick && inSlot;
    strb.slotFirst = bitTick && (int'(curPos) == FIRST_POS);
    strb.slotLast  = bitTick && (int'(curPos) == LAST_POS);
    strb.bitIdx    = offset[IDX_W-1:0];
  end
endmodule

// File: rtl/ctrlchan_dp.sv
module ctrlchan_dp
  import ctrlchan_pkg::*;
#(
  parameter int              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] TX_ADDR = ADDR_W'(5)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              softRst,
  input  logic              bitTick,
  input  logic              serIn,
  input  logic              chanEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  input  slotStrobe_t       strb,
  output logic              serOut,
  output logic              serOe,
  output logic [BYTE_W-1:0] rxByte
);
  logic [BYTE_W-1:0] txPend;
  logic [BYTE_W-1:0] txActive;
  logic [BYTE_W-2:0] rxShift;
  logic              txBit;
  logic              driveNow;

  always_comb begin
    txBit    = strb.slotFirst ? txPend[BYTE_W-1]
                              : txActive[IDX_W'(BYTE_W-1) - strb.bitIdx];
    driveNow = strb.slotTick && chanEn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txPend   <= '1;
      txActive <= '1;
    end else if (softRst) begin
      txPend   <= '1;
      txActive <= '1;
    end else begin
      if (regWrEn && regAddr == TX_ADDR) txPend <= regWrData;
      if (strb.slotFirst)                txActive <= txPend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serOe  <= 1'b0;
      serOut <= 1'b0;
    end else if (bitTick) begin
      serOe  <= driveNow;
      serOut <= driveNow && txBit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShift <= '0;
      rxByte  <= '0;
    end else if (strb.slotTick) begin
      rxShift <= {rxShift[BYTE_W-3:0], serIn};
      if (strb.slotLast) rxByte <= {rxShift, serIn};
    end
  end
endmodule

// File: rtl/ctrlchan_top.sv
module ctrlchan_top
  import ctrlchan_pkg::*;
#(
  parameter int                SLOTS_PER_FRAME = 4,
  parameter int                SLOT_INDEX      = 1,
  parameter int                ADDR_W          = 8,
  parameter logic [ADDR_W-1:0] TX_ADDR         = ADDR_W'(5)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              softRst,
  input  logic              bitTick,
  input  logic              frameSync,
  input  logic              serIn,
  output logic              serOut,
  output logic              serOe,
  input  logic              chanEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        rxByte
);
  slotStrobe_t strb;

  ctrlchan_ctl #(
    .SLOTS_PER_FRAME(SLOTS_PER_FRAME),
    .SLOT_INDEX     (SLOT_INDEX)
  ) ctl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bitTick  (bitTick),
    .frameSync(frameSync),
    .strb     (strb)
  );

  ctrlchan_dp #(
    .ADDR_W (ADDR_W),
    .TX_ADDR(TX_ADDR)
  ) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .softRst  (softRst),
    .bitTick  (bitTick),
    .serIn    (serIn),
    .chanEn   (chanEn),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strb     (strb),
    .serOut   (serOut),
    .serOe    (serOe),
    .rxByte   (rxByte)
  );
endmodule

// File: rtl/ctrlchan_chk.sv
module ctrlchan_chk
  import ctrlchan_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bitTick,
  input logic        chanEn,
  input logic        serOe,
  input logic        serOut,
  input logic [7:0]  rxByte,
  input slotStrobe_t strb
);
  // R1: no drive at a tick outside the timeslot
  a_r1_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (bitTick && !strb.slotTick) |=> !serOe);

  // R3: disabled channel leaves the timeslot undriven
  a_r3_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (bitTick && !chanEn) |=> !serOe);

  // R3: data line is parked low whenever not driving
  a_r3_out_low_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    !serOe |-> !serOut);

  // R2: outputs move only on a tick
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !bitTick |=> ($stable(serOe) && $stable(serOut)));

  // R9: received byte changes only at the end of the timeslot
  a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.slotLast |=> $stable(rxByte));
endmodule

bind ctrlchan_top ctrlchan_chk chk_i (.*);

// File: tb/ctrlchan_top_tb_top.sv
module ctrlchan_top_tb_top;
  localparam int SLOTS = 4;
  localparam int SLOT_IX = 1;
  localparam int FBITS = SLOTS * 8;
  localparam int FIRST = SLOT_IX * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic softRst = 1'b0, bitTick = 1'b0, frameSync = 1'b0, serIn = 1'b0;
  logic chanEn = 1'b0, regWrEn = 1'b0;
  logic [7:0] regAddr = '0, regWrData = '0;
  logic serOut, serOe;
  logic [7:0] rxByte;

  int checks = 0;
  int errors = 0;
  logic [7:0] pendModel = 8'hFF;
  logic [7:0] actModel  = 8'hFF;
  logic [7:0] rxModel   = 8'h00;
  int seedDummy;

  always #4 clk = ~clk;

  ctrlchan_top #(.SLOTS_PER_FRAME(SLOTS), .SLOT_INDEX(SLOT_IX)) dut_i (
    .clk(clk), .rst_n(rst_n), .softRst(softRst), .bitTick(bitTick),
    .frameSync(frameSync), .serIn(serIn), .serOut(serOut), .serOe(serOe),
    .chanEn(chanEn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .rxByte(rxByte)
  );

  function automatic logic expBit(logic [7:0] b, int k);
    return b[7-k];
  endfunction

  function automatic bit inSlot(int pos);
    return pos >= FIRST && pos < FIRST + 8;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doWrite(logic [7:0] addr, logic [7:0] data);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
    if (addr == 8'h05) pendModel = data;
  endtask

  // One frame. en: channel enable; wrPct: chance of a random write per bit;
  // forcePos/forceData: directed write after that bit's tick (forcePos<0: none)
  task automatic runFrame(logic en, int wrPct, int forcePos, logic [7:0] forceData);
    logic [7:0] rxVal;
    rxVal = 8'($urandom);
    chanEn = en;
    for (int pos = 0; pos < FBITS; pos++) begin
      int k;
      k = pos - FIRST;
      bitTick = 1'b1;
      frameSync = (pos == 0);
      serIn = inSlot(pos) ? expBit(rxVal, k) : 1'($urandom);
      if (pos == FIRST) actModel = pendModel;
      @(negedge clk);
      bitTick = 1'b0; frameSync = 1'b0;
      if (inSlot(pos)) begin
        check(en ? "R2 MSB-first bit" : "R3 disabled oe", {31'd0, serOe}, {31'd0, en});
        check(en ? "R2 MSB-first data" : "R3 disabled data",
              {31'd0, serOut}, {31'd0, en & expBit(actModel, k)});
        if (k == 7) begin
          rxModel = rxVal;
          check(en ? "R5 rx byte" : "R6 rx while disabled", {24'd0, rxByte}, {24'd0, rxModel});
        end else check("R9 rx hold", {24'd0, rxByte}, {24'd0, rxModel});
      end else begin
        check("R1 quiet outside slot", {31'd0, serOe}, 32'd0);
        check("R9 rx hold", {24'd0, rxByte}, {24'd0, rxModel});
      end
      if (pos == forcePos) doWrite(8'h05, forceData);
      else if (int'($urandom_range(99)) < wrPct)
        doWrite(($urandom_range(3) == 0) ? 8'($urandom_range(255)) : 8'h05, 8'($urandom));
      else @(negedge clk);
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    seedDummy = $urandom(32'h0C0FFEE);
    repeat (3) @(negedge clk);
    check("R4 reset oe", {31'd0, serOe}, 32'd0);
    check("R5 reset rx", {24'd0, rxByte}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: no write yet, all ones go out
    runFrame(1'b1, 0, -1, 8'h00);
    // R7: directed write then frame carries it
    doWrite(8'h05, 8'h96);
    runFrame(1'b1, 0, -1, 8'h00);
    // R7: write mid-slot keeps current slot, next frame uses new value
    runFrame(1'b1, 0, FIRST + 3, 8'h5A);
    runFrame(1'b1, 0, -1, 8'h00);
    // R8: write to another address ignored
    doWrite(8'h04, 8'h00);
    doWrite(8'h85, 8'h11);
    runFrame(1'b1, 0, -1, 8'h00);
    // R3 / R6: disabled channel still receives
    runFrame(1'b0, 0, -1, 8'h00);
    runFrame(1'b0, 20, -1, 8'h00);
    // R4: software reset presets transmit byte
    doWrite(8'h05, 8'h3C);
    softRst = 1'b1;
    @(negedge clk);
    softRst = 1'b0;
    pendModel = 8'hFF;
    actModel  = 8'hFF;
    runFrame(1'b1, 0, -1, 8'h00);
    // random mix
    for (int f = 0; f < 30; f++) runFrame(1'($urandom_range(3) != 0), 15, -1, 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule